// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counter for operating-system time slicing. Software programs a reload value through a simple word-wide register bus and turns the timer on. The counter then decrements once per reference tick. It wraps back to the reload value after it has sat at zero for one tick, so the period is reload+1 ticks. Each wrap latches a count flag. When interrupts are enabled, each wrap also emits a one-cycle interrupt-pending request.

The reference tick comes from one of two tick-enable inputs, chosen by a control bit. One input is a processor-clock enable and the other is an external reference enable. Reading the status register clears the count flag. Any write to the current-value register restarts the period. A reload value of zero turns the timer off at the next wrap, which gives a one-shot mode.

Top module: `tick_timer`

## Requirements
- R1: The control/status word has enable at bit 0, interrupt enable at bit 1, tick source at bit 2 (1 selects `cpu_tick`, 0 selects `ref_tick`) and the count flag at bit 16. A write sets only bits 2..0 from `bus_wdata[2:0]`. All other bits read as zero.
- R2: The byte offsets are: control/status at 0x10, reload at 0x14, current value at 0x18 and calibration at 0x1C. A read of any other offset returns zero, and a write to any other offset changes no register.
- R3: A status read returns the flag value from before the read, then clears the flag at that clock edge. If a wrap falls on the same edge as the read, the read returns the old value and the flag stays set.
- R4: A write of any data to the current-value offset loads the counter from the reload register and clears the count flag.
- R5: A control write that changes enable from 0 to 1 loads the reload value. While the timer is enabled, consecutive wraps are reload+1 selected ticks apart.
- R6: Every wrap sets the count flag. If interrupt enable is 1, `tick_irq` goes high for exactly one cycle, in the cycle after the wrap edge.
- R7: If the reload value is zero at a wrap, the enable bit clears and counting stops.
- R8: While the timer is disabled, the current-value offset reads 0.
- R9: A control write that keeps enable at 1 but changes the tick source reloads the counter at once.
- R10: Reset, which is synchronous and active low, clears control, flag, reload and counter.
- R11: The reload and current values are 24 bits wide, and their upper 8 bits read as zero. The calibration offset reads the constant parameter `CALIB_VALUE`.
- R12: The counter changes only on cycles where the selected tick enable is high, or when a load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_rd | input | 1 | Read strobe; its side effects apply at the edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| cpu_tick | input | 1 | Processor-clock tick enable |
| ref_tick | input | 1 | External reference tick enable |
| tick_irq | output | 1 | One-cycle interrupt-pending request |

## Verification
The critical overlap is a counter wrap on the same edge as the status read that clears the flag. The bench provokes it directly by waiting until the counter sits at zero with the selected tick held high, and then issuing the status read in that cycle. The read must return the flag clear, and a second read must then show the flag set, because the set has priority over the clear. Random traffic creates more such overlaps, and every read and every cycle of `tick_irq` is compared against a cycle-level bench model.

// File: rtl/tick_timer_pkg.sv
// Package: shared offsets, bit positions and control type for the tick timer.
// Assumes byte offsets up to 12 bits and a 32-bit data bus.
package tick_timer_pkg;

    localparam int unsigned DATA_W = 32;

    // Register byte offsets
    localparam logic [11:0] OFF_CTRL  = 12'h010;
    localparam logic [11:0] OFF_RELD  = 12'h014;
    localparam logic [11:0] OFF_CURR  = 12'h018;
    localparam logic [11:0] OFF_CALIB = 12'h01C;

    // Control/status bit positions
    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_INT  = 1;
    localparam int unsigned BIT_SRC  = 2;
    localparam int unsigned BIT_FLAG = 16;

    typedef struct packed {
        logic flag;
        logic clksrc;
        logic tickint;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/tick_regs.sv
// Module: tick_regs
// Holds the control bits, the count flag and the reload value, and decides
// when the counter must load. Assumes the strobes are already decoded and are
// one cycle wide.
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             rld_wr,
    input  logic             cur_wr,
    input  logic             stat_rd,
    input  logic [CNT_W-1:0] wdata,
    input  logic             wrap,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload,
    output logic             load_req
);

    logic reload_zero;

    // Load request: a current-value write, an enable rising edge, or a source change while running
    always_comb begin
        load_req = cur_wr;
        if (ctl_wr && wdata[BIT_EN]) begin
            if (!ctrl.en || (wdata[BIT_SRC] != ctrl.clksrc)) begin
                load_req = 1'b1;
            end
        end
    end

    assign reload_zero = (reload == '0);

    // Control bits: software writes win, otherwise auto-stop at a wrap with zero reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.en      <= 1'b0;
            ctrl.tickint <= 1'b0;
            ctrl.clksrc  <= 1'b0;
        end else if (ctl_wr) begin
            ctrl.en      <= wdata[BIT_EN];
            ctrl.tickint <= wdata[BIT_INT];
            ctrl.clksrc  <= wdata[BIT_SRC];
        end else if (wrap && reload_zero) begin
            ctrl.en      <= 1'b0;
        end
    end

    // Count flag: a wrap sets it and has priority over the read and write clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.flag <= 1'b0;
        end else if (wrap) begin
            ctrl.flag <= 1'b1;
        end else if (stat_rd || cur_wr) begin
            ctrl.flag <= 1'b0;
        end
    end

    // Reload register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (rld_wr) begin
            reload <= wdata;
        end
    end

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ctrl.flag);

    assert_autostop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && reload_zero && !ctl_wr) |=> !ctrl.en);

    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (!ctrl.en && !ctrl.flag && reload == '0));

endmodule

// File: rtl/tick_counter.sv
// Module: tick_counter
// The down-counter. It picks the tick source, decrements on selected ticks
// and reports a wrap when a tick arrives while it is at zero. A load has
// priority over counting.
module tick_counter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clksrc,
    input  logic             cpu_tick,
    input  logic             ref_tick,
    input  logic             load_req,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    logic sel_tick;
    logic step;

    // Tick source select and step qualification
    always_comb begin
        sel_tick = clksrc ? cpu_tick : ref_tick;
        step     = en && sel_tick && !load_req;
        wrap     = step && (cnt == '0);
    end

    // Counter: load, wrap to the reload value, or decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_req) begin
            cnt <= reload;
        end else if (step) begin
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (cnt == $past(reload)));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_req && !sel_tick) |=> $stable(cnt));

endmodule

// File: rtl/tick_rdmux.sv
// Module: tick_rdmux
// Combinational read-data selection. Assumes a byte offset on a word-aligned
// grid. Unmapped offsets read zero.
module tick_rdmux
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W       = 24,
    parameter int unsigned ADDR_W      = 12,
    parameter logic [31:0] CALIB_VALUE = 32'h0000_2710
) (
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             ctrl,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_W = DATA_W - CNT_W;

    logic [DATA_W-1:0] stat_word;

    // Build the control/status word at the fixed bit positions
    always_comb begin
        stat_word           = '0;
        stat_word[BIT_EN]   = ctrl.en;
        stat_word[BIT_INT]  = ctrl.tickint;
        stat_word[BIT_SRC]  = ctrl.clksrc;
        stat_word[BIT_FLAG] = ctrl.flag;
    end

    // Offset decode for reads
    always_comb begin
        if (addr == ADDR_W'(OFF_CTRL)) begin
            rdata = stat_word;
        end else if (addr == ADDR_W'(OFF_RELD)) begin
            rdata = {{PAD_W{1'b0}}, reload};
        end else if (addr == ADDR_W'(OFF_CURR)) begin
            rdata = ctrl.en ? {{PAD_W{1'b0}}, cnt} : '0;
        end else if (addr == ADDR_W'(OFF_CALIB)) begin
            rdata = CALIB_VALUE;
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/tick_timer.sv
// Module: tick_timer (top)
// A memory-mapped periodic down-counter with a count flag and a one-cycle
// interrupt request. Assumes single-cycle bus strobes and CNT_W below 32.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W       = 24,
    parameter int unsigned ADDR_W      = 12,
    parameter logic [31:0] CALIB_VALUE = 32'h0000_2710
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cpu_tick,
    input  logic              ref_tick,
    output logic              tick_irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             load_req;
    logic             wrap;
    logic             ctl_wr, rld_wr, cur_wr, stat_rd;
    logic             unused_hi;

    // Access decode
    always_comb begin
        ctl_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
        rld_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_RELD));
        cur_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_CURR));
        stat_rd = bus_rd && (bus_addr == ADDR_W'(OFF_CTRL));
    end

    assign unused_hi = ^bus_wdata[31:CNT_W];

    tick_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .rld_wr   (rld_wr),
        .cur_wr   (cur_wr),
        .stat_rd  (stat_rd),
        .wdata    (bus_wdata[CNT_W-1:0]),
        .wrap     (wrap),
        .ctrl     (ctrl),
        .reload   (reload),
        .load_req (load_req)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl.en),
        .clksrc   (ctrl.clksrc),
        .cpu_tick (cpu_tick),
        .ref_tick (ref_tick),
        .load_req (load_req),
        .reload   (reload),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    tick_rdmux #(
        .CNT_W       (CNT_W),
        .ADDR_W      (ADDR_W),
        .CALIB_VALUE (CALIB_VALUE)
    ) u_rd (
        .addr   (bus_addr),
        .ctrl   (ctrl),
        .reload (reload),
        .cnt    (cnt),
        .rdata  (bus_rdata)
    );

    // Interrupt request: one registered pulse per wrap when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_irq <= 1'b0;
        end else begin
            tick_irq <= wrap && ctrl.tickint;
        end
    end

    assert_irq_after_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |-> $past(wrap));

    assert_dis_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && bus_addr == ADDR_W'(OFF_CURR)) |-> (bus_rdata == 32'h0));

endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
// Bench for tick_timer: directed corner cases plus seeded random traffic,
// checked against a cycle-level model built from the requirements.
module tick_timer_tb;

    localparam logic [31:0] CALIB = 32'h4000_1F40;
    localparam logic [11:0] A_CTRL = 12'h010;
    localparam logic [11:0] A_RELD = 12'h014;
    localparam logic [11:0] A_CURR = 12'h018;
    localparam logic [11:0] A_CAL  = 12'h01C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_tick = 1'b0;
    logic        ref_tick = 1'b0;
    logic        tick_irq;

    int n_checks = 0;
    int n_errs   = 0;
    bit chk_irq  = 1'b0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    tick_timer #(.CNT_W(24), .ADDR_W(12), .CALIB_VALUE(CALIB)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_tick(cpu_tick), .ref_tick(ref_tick), .tick_irq(tick_irq)
    );

    // Reference model state
    logic        m_en, m_int, m_src, m_flag, m_irq;
    logic [23:0] m_rld, m_cnt;
    logic        t_tk, t_load, t_wrap, t_cw, t_uw;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= 0; m_int <= 0; m_src <= 0; m_flag <= 0; m_irq <= 0;
            m_rld <= '0; m_cnt <= '0;
        end else begin
            t_tk   = m_src ? cpu_tick : ref_tick;
            t_cw   = bus_wr && bus_addr == A_CTRL;
            t_uw   = bus_wr && bus_addr == A_CURR;
            t_load = t_uw || (t_cw && bus_wdata[0] && (!m_en || bus_wdata[2] != m_src));
            t_wrap = m_en && t_tk && !t_load && m_cnt == 0;
            if (t_load) m_cnt <= m_rld;
            else if (m_en && t_tk) m_cnt <= (m_cnt == 0) ? m_rld : m_cnt - 1;
            if (t_wrap) m_flag <= 1;
            else if (t_uw || (bus_rd && bus_addr == A_CTRL)) m_flag <= 0;
            if (t_cw) begin
                m_en <= bus_wdata[0]; m_int <= bus_wdata[1]; m_src <= bus_wdata[2];
            end else if (t_wrap && m_rld == 0) m_en <= 0;
            if (bus_wr && bus_addr == A_RELD) m_rld <= bus_wdata[23:0];
            m_irq <= t_wrap && m_int;
        end
    end

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        case (a)
            A_CTRL:  return {15'b0, m_flag, 13'b0, m_src, m_int, m_en};
            A_RELD:  return {8'b0, m_rld};
            A_CURR:  return m_en ? {8'b0, m_cnt} : 32'h0;
            A_CAL:   return CALIB;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    // Read with a check against both the model and a given constant
    task automatic rd_exp(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        check({tag, " model"}, bus_rdata, exp_rd(a));
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic rd_model(logic [11:0] a, string tag);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_rd(a));
        @(negedge clk);
        bus_rd = 0;
    endtask

    // R6: irq compared to the model every cycle
    always @(negedge clk) begin
        if (chk_irq) begin
            #0.5;
            check("R6 irq", {31'b0, tick_irq}, {31'b0, m_irq});
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        int first_irq, second_irq;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;
        chk_irq = 1;
        // R10 reset state
        rd_exp(A_CTRL, 32'h0, "R10 ctrl after reset");
        rd_exp(A_RELD, 32'h0, "R10 reload after reset");
        rd_exp(A_CURR, 32'h0, "R10 current after reset");
        // R11 width and calibration
        rd_exp(A_CAL, CALIB, "R11 calibration");
        wr(A_RELD, 32'hFFFF_FFFF);
        rd_exp(A_RELD, 32'h00FF_FFFF, "R11 reload upper bits");
        // R1 only low three bits writable
        wr(A_CTRL, 32'hFFFF_FFF8);
        rd_exp(A_CTRL, 32'h0, "R1 upper ctrl bits ignored");
        // R2 unmapped offset
        wr(12'h024, 32'h1234_5678);
        rd_exp(12'h024, 32'h0, "R2 unmapped reads zero");
        rd_exp(A_RELD, 32'h00FF_FFFF, "R2 unmapped write ignored");
        // R8 disabled current reads zero after a load
        wr(A_CURR, 32'h0);
        rd_exp(A_CURR, 32'h0, "R8 disabled current");

        // R5 period
        wr(A_RELD, 32'd4);
        cpu_tick = 1;
        wr(A_CTRL, 32'h7);
        first_irq = -1; second_irq = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            if (tick_irq) begin
                if (first_irq < 0) first_irq = i;
                else if (second_irq < 0) second_irq = i;
            end
        end
        check("R5 period reload+1", second_irq - first_irq, 32'd5);

        // R7 zero reload stops at next wrap
        wr(A_RELD, 32'd0);
        repeat (8) @(negedge clk);
        rd_exp(A_CTRL, 32'h0001_0006, "R7 enable cleared flag set");
        rd_exp(A_CTRL, 32'h0000_0006, "R3 flag cleared by read");
        rd_exp(A_CURR, 32'h0, "R8 stopped current");

        // R3 collision: status read on the wrap edge
        wr(A_RELD, 32'd3);
        wr(A_CTRL, 32'h7);
        while (m_cnt != 0) @(negedge clk);
        bus_rd = 1; bus_addr = A_CTRL;
        #1;
        check("R3 read at wrap returns old flag", bus_rdata, 32'h0000_0007);
        @(negedge clk);
        bus_rd = 0; cpu_tick = 0;
        rd_exp(A_CTRL, 32'h0001_0007, "R3 wrap beats read clear");
        rd_exp(A_CTRL, 32'h0000_0007, "R3 later read clears");

        // R4 current write reloads and clears flag
        cpu_tick = 1;
        @(negedge clk); #1;
        while (!tick_irq) begin @(negedge clk); #1; end
        cpu_tick = 0;
        wr(A_RELD, 32'd7);
        wr(A_CURR, 32'hDEAD_BEEF);
        rd_exp(A_CURR, 32'd7, "R4 current write reloads");
        rd_exp(A_CTRL, 32'h0000_0007, "R4 flag cleared by current write");

        // R9 source change reloads
        @(negedge clk); cpu_tick = 1;
        @(negedge clk); @(negedge clk); cpu_tick = 0;
        rd_exp(A_CURR, 32'd5, "R12 two cpu ticks");
        wr(A_CTRL, 32'h3);
        rd_exp(A_CURR, 32'd7, "R9 source change reload");
        // R12 only the selected tick counts
        @(negedge clk); cpu_tick = 1;
        repeat (3) @(negedge clk); cpu_tick = 0;
        rd_exp(A_CURR, 32'd7, "R12 unselected tick ignored");
        ref_tick = 1;
        repeat (3) @(negedge clk); ref_tick = 0;
        rd_exp(A_CURR, 32'd4, "R12 selected ref ticks");
        wr(A_CTRL, 32'h0);
        rd_exp(A_CURR, 32'h0, "R8 disabled by write");

        // Random traffic
        for (int it = 0; it < 3000; it++) begin
            int op;
            logic [11:0] ra;
            op = $urandom_range(0, 6);
            cpu_tick = $urandom_range(0, 1);
            ref_tick = $urandom_range(0, 1);
            case ($urandom_range(0, 5))
                0: ra = A_CTRL; 1: ra = A_RELD; 2: ra = A_CURR;
                3: ra = A_CAL;  4: ra = 12'h020; default: ra = 12'h004;
            endcase
            case (op)
                0: wr(A_CTRL, $urandom());
                1: wr(A_RELD, ($urandom() & 32'hFF00_0000) | $urandom_range(0, 12));
                2: wr(A_CURR, $urandom());
                3, 4: rd_model(ra, "R2 random read");
                5: rd_model(A_CTRL, "R3 random status read");
                default: @(negedge clk);
            endcase
        end

        // R10 reset while running
        wr(A_RELD, 32'd9);
        wr(A_CTRL, 32'h7);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd_exp(A_CTRL, 32'h0, "R10 reset while running");

        done = 1;
        chk_irq = 0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule